// File: doc/BRIEF.md
# Dual Prescaled Down-Counter Timer

This block holds two 8-bit down-counting timers, T0 and T1, each fed through its own 6-bit prescaler. A free-running divider makes an internal tick once every four system clocks. T0 counts only that tick. T1 picks its input from one of several sources: the tick, rising edges of an external pin, the tick started by an external trigger (with or without retriggering), the tick gated by the external pin, or the end-of-count pulses of T0. The external pin passes through a two-flop synchronizer, and its rising edges are detected after that.

Software programs the block through a small write port. It can set the prescaler and counter codes, choose single-pass or continuous reload, pick T1's source and the timer output, and start, stop, continue or restart each timer. The current value of either counter can be read at any time. Each timer gives a one-cycle interrupt pulse at end of count. A single output pin carries a square wave chosen from T0, T1 or the internal tick.

Top module: `prescaled_timer_pair`

## Requirements
- R1: After reset both counters read 0, both timers are stopped, and irq_t0, irq_t1 and tout are low.
- R2: A running timer with prescaler code P and counter code N gives a one-cycle irq pulse every 4*P*N clocks on the internal tick. Address 0 bits[5:0] hold T0's P and bit 6 its mode (1 = continuous). Address 1 holds T0's N. Addresses 2 and 3 do the same for T1.
- R3: A prescaler code of 0 divides by 64, and a counter code of 0 counts 256.
- R4: In single-pass mode (mode bit 0), a timer raises exactly one irq. It then stops, reads 0 and raises no further irq.
- R5: Address 4 is control: bit0 loads T0, bit1 enables T0, bit2 loads T1, bit3 enables T1. A stopped timer holds its count. Enabling without load continues from the held count. Load with enable restarts from the initial value.
- R6: Reading a counter through rd_sel (0 = T0, 1 = T1) never changes the count or the irq period.
- R7: Writing a new initial value while a timer runs does not change the count in progress. The new value takes effect at the next reload.
- R8: With T1 source 1 (address 5 bits[2:0]), T1 counts synchronized rising edges of ext_in.
- R9: With T1 source 4, T1 counts internal ticks only while ext_in is high.
- R10: With T1 source 2 or 3, enabling T1 only arms it, and a rising edge of ext_in loads and starts it. With source 2, edges during a run are ignored. With source 3, an edge during a run restarts it from its initial value.
- R11: With T1 source 5, T1 counts T0 end-of-count pulses.
- R12: Address 5 bits[5:4] select tout: 0 gives low, 1 gives the T0 square wave and 2 gives the T1 square wave (each toggles at every end of count), and 3 gives the internal tick square wave at one quarter of the clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W (8) | Write data |
| rd_sel | input | 1 | Counter read select, 0 = T0, 1 = T1 |
| rd_data | output | CNT_W (8) | Current value of the selected counter |
| ext_in | input | 1 | Asynchronous external input for T1 |
| irq_t0 | output | 1 | T0 end-of-count pulse |
| irq_t1 | output | 1 | T1 end-of-count pulse |
| tout | output | 1 | Selected square-wave output |

## Verification
The hardest case to reach is the retriggerable trigger mode. There, a second ext_in edge has to arrive while T1 is still counting and before its single pass ends. The bench arms T1 in single-pass mode with a long count, pulses ext_in, and pulses it again forty clocks later. It then checks that the irq delay measured from the first pulse grows by the same forty clocks, and that it does not grow in the non-retriggerable mode. Random prescaler and counter codes are mixed with full-range codes, so that every irq period measured at the port shows the tick, prescaler and counter chain working together.

// File: rtl/prescaled_timer_pair.sv
module prescaled_timer_pair #(
  parameter int PRE_W     = 6,
  parameter int CNT_W     = 8,
  parameter int TICK_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [CNT_W-1:0] rd_data,
  input  logic             ext_in,
  output logic             irq_t0,
  output logic             irq_t1,
  output logic             tout
);
  localparam logic [PRE_W-1:0] PONE = PRE_W'(1);
  localparam logic [CNT_W-1:0] CONE = CNT_W'(1);
  localparam logic [2:0] SRC_TICK = 3'd0, SRC_EXTCLK = 3'd1, SRC_TRIG = 3'd2,
                         SRC_RETRIG = 3'd3, SRC_GATE = 3'd4, SRC_CASC = 3'd5;

  logic [TICK_LOG2-1:0] div;
  logic [PRE_W-1:0] pcode0, pcode1, pre0, pre1;
  logic [CNT_W-1:0] init0, init1, cnt0, cnt1;
  logic cont0, cont1, run0, run1, armed1, t0q, t1q;
  logic [2:0] src1;
  logic [1:0] osel;
  logic s1, s2, s3;
  logic src_pulse;

  wire tick      = &div;
  wire ext_rise  = s2 & ~s3;
  wire trig_mode = (src1 == SRC_TRIG) || (src1 == SRC_RETRIG);
  wire in0       = run0 & tick;
  wire pe0       = in0 && (pre0 == PONE);
  wire eoc0      = pe0 && (cnt0 == CONE);
  wire in1       = run1 & src_pulse;
  wire pe1       = in1 && (pre1 == PONE);
  wire eoc1      = pe1 && (cnt1 == CONE);
  wire trig_fire = trig_mode && armed1 && ext_rise && (!run1 || src1 == SRC_RETRIG);
  wire wr_ctrl   = wr_en && (wr_addr == 3'd4);

  always_comb begin
    case (src1)
      SRC_TICK, SRC_TRIG, SRC_RETRIG: src_pulse = tick;
      SRC_EXTCLK: src_pulse = ext_rise;
      SRC_GATE:   src_pulse = tick & s2;
      SRC_CASC:   src_pulse = eoc0;
      default:    src_pulse = 1'b0;
    endcase
  end

  assign rd_data = rd_sel ? cnt1 : cnt0;

  always_comb begin
    case (osel)
      2'd0:    tout = 1'b0;
      2'd1:    tout = t0q;
      2'd2:    tout = t1q;
      default: tout = div[TICK_LOG2-1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div <= '0;
      {s1, s2, s3} <= 3'b000;
      irq_t0 <= 1'b0;
      irq_t1 <= 1'b0;
      t0q <= 1'b0;
      t1q <= 1'b0;
    end else begin
      div <= div + TICK_LOG2'(1);
      {s1, s2, s3} <= {ext_in, s1, s2};
      irq_t0 <= eoc0;
      irq_t1 <= eoc1;
      t0q <= t0q ^ eoc0;
      t1q <= t1q ^ eoc1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcode0 <= '0; init0 <= '0; pre0 <= '0; cnt0 <= '0;
      cont0 <= 1'b0; run0 <= 1'b0;
    end else begin
      if (in0) begin
        if (pe0) begin
          pre0 <= pcode0;
          if (cnt0 == CONE) begin
            if (cont0) cnt0 <= init0;
            else begin
              cnt0 <= '0;
              run0 <= 1'b0;
            end
          end else cnt0 <= cnt0 - CONE;
        end else pre0 <= pre0 - PONE;
      end
      if (wr_en && wr_addr == 3'd0) begin
        pcode0 <= wr_data[PRE_W-1:0];
        cont0  <= wr_data[PRE_W];
      end
      if (wr_en && wr_addr == 3'd1) init0 <= wr_data;
      if (wr_ctrl) begin
        run0 <= wr_data[1];
        if (wr_data[0]) begin
          pre0 <= pcode0;
          cnt0 <= init0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcode1 <= '0; init1 <= '0; pre1 <= '0; cnt1 <= '0;
      cont1 <= 1'b0; run1 <= 1'b0; armed1 <= 1'b0;
      src1 <= SRC_TICK; osel <= 2'd0;
    end else begin
      if (in1) begin
        if (pe1) begin
          pre1 <= pcode1;
          if (cnt1 == CONE) begin
            if (cont1) cnt1 <= init1;
            else begin
              cnt1 <= '0;
              run1 <= 1'b0;
            end
          end else cnt1 <= cnt1 - CONE;
        end else pre1 <= pre1 - PONE;
      end
      if (trig_fire) begin
        pre1 <= pcode1;
        cnt1 <= init1;
        run1 <= 1'b1;
      end
      if (wr_en && wr_addr == 3'd2) begin
        pcode1 <= wr_data[PRE_W-1:0];
        cont1  <= wr_data[PRE_W];
      end
      if (wr_en && wr_addr == 3'd3) init1 <= wr_data;
      if (wr_en && wr_addr == 3'd5) begin
        src1 <= wr_data[2:0];
        osel <= wr_data[5:4];
      end
      if (wr_ctrl) begin
        armed1 <= wr_data[3];
        run1   <= wr_data[3] && !trig_mode;
        if (wr_data[2]) begin
          pre1 <= pcode1;
          cnt1 <= init1;
        end
      end
    end
  end

  AST_IRQ0_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) irq_t0 |=> !irq_t0); // R2
  AST_IRQ1_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) irq_t1 |=> !irq_t1); // R2
  AST_IRQ0_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n) irq_t0 |-> $past(run0)); // R1
  AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_t0 && !cont0 && !$past(wr_en)) |-> (!run0 && cnt0 == '0)); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run0 && !wr_en) |=> $stable(cnt0)); // R5
  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (src1 == SRC_GATE && !s2 && !wr_en) |=> $stable(cnt1)); // R9
  AST_ARMED_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_mode && !run1 && !ext_rise && !wr_en) |=> !run1); // R10
endmodule

// File: tb/tb_prescaled_timer_pair.sv
module tb_prescaled_timer_pair;
  logic clk = 1'b0;
  logic rst_n = 1'b0, wr_en = 1'b0, rd_sel = 1'b0, ext_in = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic irq_t0, irq_t1, tout;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  prescaled_timer_pair dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .ext_in(ext_in),
    .irq_t0(irq_t0), .irq_t1(irq_t1), .tout(tout));

  function automatic int exp_period(int p, int n);
    return 4 * (p == 0 ? 64 : p) * (n == 0 ? 256 : n);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_irq(input int w, input int maxc, output int n);
    n = 0;
    forever begin
      @(negedge clk);
      rd_sel = 1'($urandom_range(0, 1));
      n++;
      if ((w == 0) ? irq_t0 : irq_t1) return;
      if (n >= maxc) begin n = -1; return; end
    end
  endtask

  task automatic meas(input int w, input int maxc, output int gap);
    int t;
    wait_irq(w, maxc, t);
    if (t < 0) gap = -1;
    else wait_irq(w, maxc, gap);
  endtask

  task automatic count_irq(input int w, input int cyc, output int c);
    c = 0;
    repeat (cyc) begin
      @(negedge clk);
      if ((w == 0) ? irq_t0 : irq_t1) c++;
    end
  endtask

  task automatic count_edges(input int cyc, output int c);
    logic prev;
    @(negedge clk);
    prev = tout; c = 0;
    repeat (cyc) begin
      @(negedge clk);
      if (tout != prev) c++;
      prev = tout;
    end
  endtask

  task automatic trig_run(input bit second, output int t);
    t = 0;
    ext_in = 1'b1;
    forever begin
      @(negedge clk);
      t++;
      if (t == 4 || t == 44) ext_in = 1'b0;
      if (second && t == 40) ext_in = 1'b1;
      if (irq_t1) return;
      if (t > 300) begin t = -1; ext_in = 1'b0; return; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not finish");
    report();
    $finish;
  end

  initial begin
    int p, n, g, t, c, v1, v2, v3;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_sel = 1'b0;
    chk(rd_data == 0 && !irq_t0 && !irq_t1 && !tout, "R1 reset outputs", int'(rd_data), 0);
    rd_sel = 1'b1; #1;
    chk(rd_data == 0, "R1 reset T1 count", int'(rd_data), 0);
    count_irq(0, 100, c);
    chk(c == 0, "R1 stopped after reset", c, 0);

    for (int i = 0; i < 6; i++) begin
      p = $urandom_range(1, 8); n = $urandom_range(1, 12);
      wr(0, 8'h40 | p); wr(1, n); wr(4, 8'h03);
      meas(0, exp_period(p, n) + 20, g);
      chk(g == exp_period(p, n), "R2 T0 period", g, exp_period(p, n));
    end
    for (int i = 0; i < 3; i++) begin
      p = $urandom_range(1, 8); n = $urandom_range(1, 12);
      wr(5, 0); wr(2, 8'h40 | p); wr(3, n); wr(4, 8'h0C);
      meas(1, exp_period(p, n) + 20, g);
      chk(g == exp_period(p, n), "R2 T1 period", g, exp_period(p, n));
    end
    wr(4, 0);

    wr(0, 8'h40); wr(1, 2); wr(4, 3);
    meas(0, 1200, g);
    chk(g == 512, "R3 prescaler code 0", g, 512);
    wr(0, 8'h41); wr(1, 0); wr(4, 3);
    meas(0, 1200, g);
    chk(g == 1024, "R3 counter code 0", g, 1024);

    wr(0, 8'h02); wr(1, 3); wr(4, 3);
    wait_irq(0, 60, t);
    chk(t > 0, "R4 single pass irq", t, 1);
    count_irq(0, 200, c);
    rd_sel = 1'b0; #1;
    chk(c == 0, "R4 no further irq", c, 0);
    chk(rd_data == 0, "R4 reads zero", int'(rd_data), 0);

    wr(0, 8'h41); wr(1, 200); wr(4, 3);
    repeat (40) @(negedge clk);
    wr(4, 0);
    rd_sel = 1'b0; #1; v1 = int'(rd_data);
    chk(v1 >= 185 && v1 <= 195, "R5 count before stop", v1, 190);
    repeat (50) @(negedge clk);
    v2 = int'(rd_data);
    chk(v2 == v1, "R5 stopped holds", v2, v1);
    wr(4, 2);
    repeat (20) @(negedge clk);
    v3 = int'(rd_data);
    chk(v3 < v1 && v3 >= v1 - 6, "R5 continue from held", v3, v1 - 5);
    wr(4, 3);
    rd_sel = 1'b0; #1;
    chk(rd_data == 200, "R5 restart from initial", int'(rd_data), 200);

    wr(0, 8'h43); wr(1, 5); wr(4, 3);
    meas(0, 100, g);
    chk(g == 60, "R6 period with reads toggling", g, 60);

    wr(0, 8'h41); wr(1, 10); wr(4, 3); wr(1, 50);
    wait_irq(0, 100, t);
    chk(t > 0 && t <= 44, "R7 count in progress kept", t, 40);
    wait_irq(0, 300, g);
    chk(g == 200, "R7 new initial at reload", g, 200);
    wr(4, 0);

    wr(5, 1); wr(2, 8'h42); wr(3, 3); wr(4, 8'h0C);
    c = 0;
    repeat (12) begin
      ext_in = 1'b1;
      repeat (3) begin @(negedge clk); if (irq_t1) c++; end
      ext_in = 1'b0;
      repeat (3) begin @(negedge clk); if (irq_t1) c++; end
    end
    count_irq(1, 10, t);
    c += t;
    chk(c == 2, "R8 external clock edges", c, 2);

    wr(5, 4); wr(2, 8'h41); wr(3, 5); wr(4, 8'h0C);
    count_irq(1, 200, c);
    chk(c == 0, "R9 gate closed", c, 0);
    ext_in = 1'b1;
    meas(1, 100, g);
    chk(g == 20, "R9 gate open period", g, 20);
    ext_in = 1'b0;

    wr(5, 2); wr(2, 8'h01); wr(3, 20); wr(4, 8'h0C);
    count_irq(1, 30, c);
    rd_sel = 1'b1; #1;
    chk(c == 0 && rd_data == 20, "R10 armed waits", int'(rd_data), 20);
    trig_run(1'b1, t);
    chk(t >= 75 && t <= 90, "R10 non-retrigger ignores edge", t, 82);
    wr(5, 3); wr(4, 8'h0C);
    repeat (5) @(negedge clk);
    trig_run(1'b1, t);
    chk(t >= 115 && t <= 130, "R10 retrigger restarts", t, 122);

    wr(5, 5); wr(0, 8'h41); wr(1, 2); wr(2, 8'h41); wr(3, 3); wr(4, 8'h0F);
    meas(1, 100, g);
    chk(g == 24, "R11 cascade period", g, 24);

    wr(5, 8'h15);
    count_edges(80, c);
    chk(c == 10, "R12 tout from T0", c, 10);
    wr(5, 8'h25);
    count_edges(96, c);
    chk(c == 4, "R12 tout from T1", c, 4);
    wr(5, 8'h35);
    count_edges(80, c);
    chk(c == 40, "R12 tout internal tick", c, 40);
    wr(5, 8'h05);
    count_edges(40, c);
    chk(c == 0 && !tout, "R12 tout off", c, 0);

    report();
    $finish;
  end
endmodule